// File: doc/BRIEF.md
# Bit-Serial CRC Accumulator with Carry Input

This block adds one data bit per operation to a running CRC. A serial transmitter or receiver can then keep the checksum current while each bit of a frame goes out or comes in. The reply can be sent as soon as the last bit arrives, with no long CRC pass at the end of the frame. The bit to fold comes in on a carry-style input. The polynomial is a loadable 32-bit register, so any width or generator up to 32 bits can be used. The update uses the right-shifting (reflected) form, and data is taken least significant bit first. For CRC-16 the usual generator 0x8005 is loaded in its bit-reversed form, 0xA001.

Software first writes the polynomial and a seed, usually 0x0000 or 0xFFFF. It then issues a single-bit step for each bit of the frame and reads the CRC register at the end. An optional byte mode accepts a whole byte with one start strobe. It then folds the byte's eight bits on its own, one per cycle, and holds a busy flag while it works. Inverting the final value and ordering its bytes for transmission are left to software.

Top module: `serial_crc_engine`

## Requirements
- R1: One fold works as follows. Let X be the incoming bit XOR bit 0 of the CRC. The CRC shifts right by one and a 0 enters bit 31. If X is 1, the shifted value is then XORed with the polynomial register; if X is 0, it is kept as shifted.
- R2: `crc_load` writes `crc_data` into the CRC at the next clock edge. `poly_load` writes `poly_data` into the polynomial at the next clock edge and leaves `crc_out` unchanged.
- R3: A single-bit step takes two cycles. A `step_req` sampled at edge k with bit `carry_in` shows up on `crc_out` after edge k+1, and `crc_out` is still unchanged after edge k. A new step can be accepted on every cycle.
- R4: In byte mode, a `byte_start` accepted at edge k folds `byte_data` bit 0 first, one bit per edge from k+1 to k+8. The result equals eight single-bit steps over the same bits.
- R5: `busy` rises after an accepted `byte_start` edge and falls after the eighth fold edge. It is never high for more than 8 cycles in a row.
- R6: `step_req` and `byte_start` that arrive while `busy` is high are ignored.
- R7: A load takes priority over stepping. A `crc_load` or `poly_load` at an edge cancels any `step_req` or `byte_start` sampled at that same edge, discards a step still pending, and ends a byte run so that `busy` goes low.
- R8: When `byte_start` and `step_req` are both sampled at the same idle edge, only the byte run takes place.
- R9: After reset, `crc_out`, the polynomial and `busy` are all zero.
- R10: With seeds of 0x0000 and 0xFFFF and several polynomials, the accumulated value matches a bitwise model of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poly_load | input | 1 | Write `poly_data` into the polynomial register |
| poly_data | input | 32 | Polynomial value (reflected form) |
| crc_load | input | 1 | Write `crc_data` into the CRC register |
| crc_data | input | 32 | Seed value for the CRC |
| step_req | input | 1 | Fold `carry_in` into the CRC |
| carry_in | input | 1 | Data bit for a single step |
| byte_start | input | 1 | Start an eight-bit run over `byte_data` |
| byte_data | input | 8 | Byte to fold, bit 0 first |
| crc_out | output | 32 | Current CRC value |
| busy | output | 1 | High while a byte run is in progress |

## Verification
A table of seed, polynomial and byte triples is run twice: once as eight single steps and once as one byte run. Each result is compared with a bitwise model. Using both 0x0000 and 0xFFFF seeds and polynomials with different low and high bits makes the test fail if the XOR condition, the shift direction or the zero fill is wrong. If the bit order inside the byte sequencer is wrong, the single-step and byte-run results disagree. Directed cases check the two-cycle latency by sampling one cycle early. They also start collisions between a load and a step or byte run, and between a step and a byte start, and send requests during a busy run to show that they leave `crc_out` unchanged.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

  localparam int unsigned CRC_W  = 32;
  localparam int unsigned BYTE_W = 8;

  // One reflected fold: feedback is the data bit against the outgoing LSB.
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] cur,
                                                input logic [CRC_W-1:0] poly,
                                                input logic             din);
    logic fb;
    fb = din ^ cur[0];
    return (cur >> 1) ^ ({CRC_W{fb}} & poly);
  endfunction

endpackage

// File: rtl/crc_step_stage.sv
// Holds one accepted single-bit request for one cycle (two-cycle step).
module crc_step_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic bit_in,
  input  logic cancel,
  output logic fire,
  output logic fire_bit
);
  logic pend_q;
  logic bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      pend_q <= accept;
      if (accept) bit_q <= bit_in;
    end
  end

  assign fire     = pend_q & ~cancel;
  assign fire_bit = bit_q;
endmodule

// File: rtl/crc_byte_sequencer.sv
// Feeds the bits of one byte into the fold, LSB first, one per cycle.
module crc_byte_sequencer #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] data,
  input  logic              abort,
  output logic              busy,
  output logic              fire,
  output logic              fire_bit
);
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (abort) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      sh_q   <= data;
      cnt_q  <= CNT_W'(BYTE_W);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      sh_q  <= sh_q >> 1;
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign fire     = busy_q & ~abort;
  assign fire_bit = sh_q[0];
endmodule

// File: rtl/crc_accum_reg.sv
// Polynomial and CRC registers with load priority over the fold.
module crc_accum_reg
  import crc_serial_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poly_wr,
  input  logic [CRC_W-1:0] poly_val,
  input  logic             crc_wr,
  input  logic [CRC_W-1:0] crc_val,
  input  logic             fold_en,
  input  logic             fold_bit,
  output logic [CRC_W-1:0] crc_q
);
  logic [CRC_W-1:0] poly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly_q <= '0;
      crc_q  <= '0;
    end else begin
      if (poly_wr) poly_q <= poly_val;
      if (crc_wr)       crc_q <= crc_val;
      else if (fold_en) crc_q <= crc_fold(crc_q, poly_q, fold_bit);
    end
  end
endmodule

// File: rtl/serial_crc_engine.sv
module serial_crc_engine
  import crc_serial_pkg::*;
#(
  parameter bit BYTE_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poly_load,
  input  logic [CRC_W-1:0]  poly_data,
  input  logic              crc_load,
  input  logic [CRC_W-1:0]  crc_data,
  input  logic              step_req,
  input  logic              carry_in,
  input  logic              byte_start,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [CRC_W-1:0]  crc_out,
  output logic              busy
);
  // Named internal events, used by the checker.
  logic any_load;
  logic step_accept;
  logic pend_fire;
  logic pend_bit;
  logic seq_fire;
  logic seq_bit;
  logic seq_busy;
  logic fold_en;
  logic fold_bit;

  assign any_load    = crc_load | poly_load;
  assign step_accept = step_req & ~seq_busy & ~byte_start & ~any_load;

  crc_step_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (step_accept),
    .bit_in   (carry_in),
    .cancel   (any_load),
    .fire     (pend_fire),
    .fire_bit (pend_bit)
  );

  generate
    if (BYTE_MODE) begin : g_byte
      crc_byte_sequencer #(.BYTE_W(BYTE_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (byte_start),
        .data     (byte_data),
        .abort    (any_load),
        .busy     (seq_busy),
        .fire     (seq_fire),
        .fire_bit (seq_bit)
      );
    end else begin : g_nobyte
      assign seq_busy = 1'b0;
      assign seq_fire = 1'b0;
      assign seq_bit  = 1'b0;
    end
  endgenerate

  assign fold_en  = pend_fire | seq_fire;
  assign fold_bit = seq_fire ? seq_bit : pend_bit;

  crc_accum_reg u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .poly_wr  (poly_load),
    .poly_val (poly_data),
    .crc_wr   (crc_load),
    .crc_val  (crc_data),
    .fold_en  (fold_en),
    .fold_bit (fold_bit),
    .crc_q    (crc_out)
  );

  assign busy = seq_busy;
endmodule

// File: rtl/crc_engine_checker.sv
module crc_engine_checker
  import crc_serial_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             crc_load,
  input logic             poly_load,
  input logic [CRC_W-1:0] crc_data,
  input logic             byte_start,
  input logic             busy,
  input logic [CRC_W-1:0] crc_out,
  input logic             pend_fire,
  input logic             seq_fire
);
  logic [4:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (busy) busy_run <= busy_run + 5'd1;
    else busy_run <= '0;
  end

  assert_crc_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    crc_load |=> crc_out == $past(crc_data));

  assert_poly_keeps_crc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (poly_load && !crc_load) |=> $stable(crc_out));

  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_fire && !seq_fire && !crc_load) |=> $stable(crc_out));

  assert_single_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_fire && seq_fire));

  assert_busy_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_start && !busy && !crc_load && !poly_load) |=> busy);

  assert_load_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_load || poly_load) |=> !busy);

  always_comb begin
    if (rst_n) assert_busy_bounded_R5: assert (busy_run <= 5'(BYTE_W));
  end
endmodule

bind serial_crc_engine crc_engine_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .crc_load   (crc_load),
  .poly_load  (poly_load),
  .crc_data   (crc_data),
  .byte_start (byte_start),
  .busy       (busy),
  .crc_out    (crc_out),
  .pend_fire  (pend_fire),
  .seq_fire   (seq_fire)
);

// File: tb/serial_crc_engine_bench.sv
`timescale 1ns/1ps
module serial_crc_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poly_load = 1'b0;
  logic [31:0] poly_data = '0;
  logic        crc_load = 1'b0;
  logic [31:0] crc_data = '0;
  logic        step_req = 1'b0;
  logic        carry_in = 1'b0;
  logic        byte_start = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [31:0] crc_out;
  logic        busy;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  serial_crc_engine u_serial_crc_engine (
    .clk(clk), .rst_n(rst_n), .poly_load(poly_load), .poly_data(poly_data),
    .crc_load(crc_load), .crc_data(crc_data), .step_req(step_req),
    .carry_in(carry_in), .byte_start(byte_start), .byte_data(byte_data),
    .crc_out(crc_out), .busy(busy)
  );

  // seed, polynomial, byte
  localparam logic [71:0] VECS [0:5] = '{
    {32'h0000_0000, 32'h0000_A001, 8'h31},
    {32'h0000_FFFF, 32'h0000_A001, 8'h31},
    {32'h0000_FFFF, 32'h0000_A001, 8'hA5},
    {32'h0000_0000, 32'hEDB8_8320, 8'hFF},
    {32'hFFFF_FFFF, 32'hEDB8_8320, 8'h5A},
    {32'h0000_FFFF, 32'h0000_8408, 8'h00}
  };

  // Model of R1 written bit by bit.
  function automatic logic [31:0] model_bit(input logic [31:0] c, input logic [31:0] p,
                                            input logic b);
    logic [31:0] n;
    n = {1'b0, c[31:1]};
    if (b != c[0]) n = n ^ p;
    return n;
  endfunction

  function automatic logic [31:0] model_byte(input logic [31:0] c, input logic [31:0] p,
                                             input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = model_bit(r, p, d[i]);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_regs(input logic [31:0] p, input logic [31:0] s);
    @(negedge clk);
    poly_load = 1'b1; poly_data = p;
    @(negedge clk);
    poly_load = 1'b0;
    crc_load = 1'b1; crc_data = s;
    @(negedge clk);
    crc_load = 1'b0;
  endtask

  task automatic step(input logic b);
    step_req = 1'b1; carry_in = b;
    @(negedge clk);
    step_req = 1'b0;
  endtask

  task automatic start_byte(input logic [7:0] d);
    byte_start = 1'b1; byte_data = d;
    @(negedge clk);
    byte_start = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] exp;
    logic [31:0] hold;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 crc", crc_out, 32'h0);
    check("R9 busy", {31'b0, busy}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table: serial steps and byte run must both match the model (R1, R4, R10)
    for (int v = 0; v < 6; v++) begin
      exp = model_byte(VECS[v][71:40], VECS[v][39:8], VECS[v][7:0]);
      set_regs(VECS[v][39:8], VECS[v][71:40]);
      for (int i = 0; i < 8; i++) step(VECS[v][i]);
      @(negedge clk);
      check("R1 R10 serial", crc_out, exp);
      set_regs(VECS[v][39:8], VECS[v][71:40]);
      start_byte(VECS[v][7:0]);
      repeat (8) @(negedge clk);
      check("R4 R10 byte", crc_out, exp);
    end

    // R3: two-cycle latency
    set_regs(32'h0000_A001, 32'h0000_0001);
    step(1'b0);
    check("R3 early", crc_out, 32'h0000_0001);
    @(negedge clk);
    check("R3 done", crc_out, model_bit(32'h1, 32'hA001, 1'b0));

    // R2: poly load leaves crc unchanged
    hold = crc_out;
    @(negedge clk); poly_load = 1'b1; poly_data = 32'h1234_5678;
    @(negedge clk); poly_load = 1'b0;
    check("R2 poly keeps crc", crc_out, hold);

    // R5: busy window
    set_regs(32'h0000_A001, 32'h0000_FFFF);
    start_byte(8'h3C);
    check("R5 busy after start", {31'b0, busy}, 32'h1);
    repeat (7) @(negedge clk);
    check("R5 busy at 7", {31'b0, busy}, 32'h1);
    @(negedge clk);
    check("R5 busy clear", {31'b0, busy}, 32'h0);

    // R6: step and byte_start while busy are ignored
    set_regs(32'h0000_A001, 32'h0000_FFFF);
    start_byte(8'h3C);
    step(1'b1);
    byte_start = 1'b1; byte_data = 8'hFF;
    @(negedge clk); byte_start = 1'b0;
    repeat (7) @(negedge clk);
    check("R6 busy ignores", crc_out, model_byte(32'hFFFF, 32'hA001, 8'h3C));

    // R7: load at the same edge as a step wins
    set_regs(32'h0000_A001, 32'h0000_0000);
    crc_load = 1'b1; crc_data = 32'h0000_1357;
    step(1'b1);
    crc_load = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 load beats step", crc_out, 32'h0000_1357);

    // R7: load aborts a byte run
    start_byte(8'hFF);
    @(negedge clk); @(negedge clk);
    crc_load = 1'b1; crc_data = 32'h0000_2468;
    @(negedge clk); crc_load = 1'b0;
    check("R7 abort busy", {31'b0, busy}, 32'h0);
    repeat (3) @(negedge clk);
    check("R7 abort value", crc_out, 32'h0000_2468);

    // R8: byte_start beats step_req at the same edge
    set_regs(32'h0000_A001, 32'h0000_FFFF);
    byte_start = 1'b1; byte_data = 8'h81; step_req = 1'b1; carry_in = 1'b1;
    @(negedge clk);
    byte_start = 1'b0; step_req = 1'b0;
    repeat (9) @(negedge clk);
    check("R8 byte wins", crc_out, model_byte(32'hFFFF, 32'hA001, 8'h81));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule